// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects synchronous on-chip logic to an external byte-wide asynchronous static RAM. The RAM has a 19-bit address and an 8-bit data bus that goes both ways. Internal logic issues a one-cycle request strobe with an address, a direction flag and write data. The controller then runs a complete memory cycle on the active-low select, output-enable and write-enable pins. When the cycle is finished it raises a one-cycle ready pulse, and for a read it also presents the captured byte.

Phase lengths are given as nanosecond-scale limits in picoseconds, together with the clock period. Each one is rounded up to whole clock cycles when the design is elaborated. On a write, the controller holds output-enable high and keeps its own data driver off until a turnaround delay has passed, so the memory and the controller never drive the bus at the same time. When no cycle is in progress, all three control pins stay high and the data bus is released.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, mem_ce_n, mem_oe_n and mem_we_n are 1 and ready is 0.
- R2: Outside a memory cycle, mem_ce_n, mem_oe_n and mem_we_n are all 1 and the controller's data driver is off.
- R3: A request with wr=0 gives a read phase in which mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RD cycles. During that phase mem_addr holds the request address. In the cycle after the phase, ready=1 and rdata holds the memory byte at that address.
- R4: A request with wr=1 holds mem_we_n at 0 for exactly WL cycles, with mem_ce_n=0, mem_oe_n=1 and mem_addr equal to the request address. At the end the memory holds wdata at that address.
- R5: The controller drives mem_dq only while mem_oe_n=1, and it does not drive the bus during the first TA cycles after mem_we_n falls.
- R6: After mem_we_n rises at the end of a write, mem_ce_n stays 0 for exactly one more cycle, and the write data is still driven on mem_dq in that cycle.
- R7: ready is high for exactly one cycle per accepted request. It is asserted in the first cycle after mem_ce_n returns to 1.
- R8: A request that arrives while a cycle is in progress is ignored. It starts no memory cycle and changes no memory byte.
- R9: The phase counts are TA = max(1, ceil(T_HZ_PS/CLK_PS)), RD = max(1, ceil(T_AA_PS/CLK_PS)) and WL = max(TA + max(1, ceil(T_SD_PS/CLK_PS)), ceil(T_WP_PS/CLK_PS)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle request strobe, taken only when idle |
| wr | input | 1 | Direction: 1 = write, 0 = read |
| addr | input | ADDR_W | Request address |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Byte captured by the last read |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq | inout | DATA_W | Memory data bus, tristate |

## Verification
The bench builds the controller with a 20 ns clock period and limits of 30 ns turnaround, 15 ns data setup, 70 ns write pulse and 50 ns access. These give a two-cycle turnaround, a three-cycle read and a four-cycle write-enable pulse. Because the write pulse comes from the pulse-width limit and not from turnaround plus setup, the maximum in the rounding rule matters. Multi-cycle phases also let the bench see the driver stay off through the turnaround and the address stay stable through the access. A bench memory model answers reads combinationally and stores a byte on the rising edge of write-enable.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_PS  = 10000,
  parameter int T_WP_PS = 7000,
  parameter int T_SD_PS = 6000,
  parameter int T_AA_PS = 10000,
  parameter int T_HZ_PS = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int TA_CYC  = cyc(T_HZ_PS);
  localparam int RD_CYC  = cyc(T_AA_PS);
  localparam int SD_CYC  = cyc(T_SD_PS);
  localparam int WP_CYC  = cyc(T_WP_PS);
  localparam int WL_CYC  = (TA_CYC + SD_CYC > WP_CYC) ? TA_CYC + SD_CYC : WP_CYC;
  localparam int DRV_CYC = WL_CYC - TA_CYC;
  localparam int MAX_CYC = (RD_CYC > WL_CYC) ? RD_CYC : WL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_WTA, ST_WDRV, ST_WHOLD} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] wd_q;
  logic              dq_oe;
  logic              last;

  assign last   = (cnt == '0);
  assign mem_dq = dq_oe ? wd_q : 'z;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      wd_q     <= '0;
      dq_oe    <= 1'b0;
      ready    <= 1'b0;
      rdata    <= '0;
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_addr <= '0;
    end else begin
      ready <= 1'b0;
      case (st)
        ST_IDLE: if (req) begin
          mem_addr <= addr;
          mem_ce_n <= 1'b0;
          if (wr) begin
            wd_q     <= wdata;
            mem_we_n <= 1'b0;
            cnt      <= CNT_W'(TA_CYC - 1);
            st       <= ST_WTA;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CNT_W'(RD_CYC - 1);
            st       <= ST_READ;
          end
        end
        ST_READ: if (last) begin
          rdata    <= mem_dq;
          ready    <= 1'b1;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          st       <= ST_IDLE;
        end else cnt <= cnt - 1'b1;
        ST_WTA: if (last) begin
          dq_oe <= 1'b1;
          cnt   <= CNT_W'(DRV_CYC - 1);
          st    <= ST_WDRV;
        end else cnt <= cnt - 1'b1;
        ST_WDRV: if (last) begin
          mem_we_n <= 1'b1;
          st       <= ST_WHOLD;
        end else cnt <= cnt - 1'b1;
        ST_WHOLD: begin
          mem_ce_n <= 1'b1;
          dq_oe    <= 1'b0;
          ready    <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              dq_oe,
  input logic              ready,
  input logic [ADDR_W-1:0] mem_addr
);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_oe_n && mem_we_n && !dq_oe));

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> mem_oe_n);

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !dq_oe);

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  assert_write_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  assert_hold_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && dq_oe));

  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> mem_ce_n);

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .dq_oe(dq_oe), .ready(ready), .mem_addr(mem_addr)
);

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;
  localparam int AW = 19, DW = 8;
  localparam int CLK_PS = 20000, T_WP = 70000, T_SD = 15000, T_AA = 50000, T_HZ = 30000;

  function automatic int up(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int E_TA = up(T_HZ);
  localparam int E_RD = up(T_AA);
  localparam int E_WL = (E_TA + up(T_SD) > up(T_WP)) ? E_TA + up(T_SD) : up(T_WP);

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, mem_ce_n, mem_oe_n, mem_we_n;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [DW-1:0] model_mem [logic [AW-1:0]];
  logic [DW-1:0] shadow    [logic [AW-1:0]];
  logic          m_en;
  logic [DW-1:0] m_q;

  always #10ns clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .T_WP_PS(T_WP),
              .T_SD_PS(T_SD), .T_AA_PS(T_AA), .T_HZ_PS(T_HZ)) i_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq(mem_dq));

  function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
    return a[7:0] ^ {5'b0, a[18:16]} ^ 8'h3C;
  endfunction

  always_comb begin
    m_en = rst_n && !mem_ce_n && !mem_oe_n && mem_we_n;
    m_q  = model_mem.exists(mem_addr) ? model_mem[mem_addr] : dflt(mem_addr);
  end
  assign mem_dq = m_en ? m_q : 'z;

  always @(posedge mem_we_n) if (rst_n === 1'b1 && mem_ce_n === 1'b0) model_mem[mem_addr] = mem_dq;

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
    return shadow.exists(a) ? shadow[a] : dflt(a);
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish_run();
    end
  end

  task automatic txn(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input bit poke, input logic [AW-1:0] pa);
    int n;
    bit poked;
    n = 0; poked = 0;
    @(negedge clk); req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk); req = 0;
    if (w) begin
      while (mem_we_n == 1'b0) begin
        if (poked) req = 0;
        chk(mem_oe_n && !mem_ce_n, "R4 oe high ce low", {mem_oe_n, mem_ce_n}, 2'b10);
        chk(mem_addr == a, "R4 address", mem_addr, a);
        if (n < E_TA && d != 0) chk(mem_dq !== d, "R5 bus released in turnaround", mem_dq, 0);
        if (n >= E_TA) chk(mem_dq === d, "R4 write data driven", mem_dq, d);
        if (poke && !poked) begin req = 1; wr = 1; addr = pa; wdata = ~d; poked = 1; end
        n++;
        @(negedge clk);
      end
      req = 0;
      chk(n == E_WL, "R4 R9 write pulse length", n, E_WL);
      chk(!mem_ce_n && mem_we_n, "R6 hold cycle ce low", mem_ce_n, 0);
      chk(mem_dq === d, "R6 data held after we rise", mem_dq, d);
      @(negedge clk);
      chk(mem_ce_n && ready, "R7 ready after write", {mem_ce_n, ready}, 2'b11);
      shadow[a] = d;
    end else begin
      while (mem_oe_n == 1'b0) begin
        if (poked) req = 0;
        chk(!mem_ce_n && mem_we_n, "R3 read controls", {mem_ce_n, mem_we_n}, 2'b01);
        chk(mem_addr == a, "R3 address stable", mem_addr, a);
        if (poke && !poked) begin req = 1; wr = 1; addr = pa; wdata = 8'h99; poked = 1; end
        n++;
        @(negedge clk);
      end
      req = 0;
      chk(n == E_RD, "R3 R9 access length", n, E_RD);
      chk(ready === 1'b1, "R7 ready after read", ready, 1);
      chk(rdata == expect_rd(a), "R3 read data", rdata, expect_rd(a));
      chk(mem_ce_n && mem_we_n, "R2 deselect after read", {mem_ce_n, mem_we_n}, 2'b11);
    end
    @(negedge clk);
    chk(ready === 1'b0, "R7 single ready pulse", ready, 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R2 idle controls", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 controls in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(ready === 1'b0, "R1 ready in reset", ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 controls after reset", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R2 idle without request", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);

    txn(0, 19'h00000, 8'h00, 0, '0);
    txn(1, 19'h00000, 8'hFF, 0, '0);
    txn(0, 19'h00000, 8'h00, 0, '0);
    txn(1, 19'h7FFFF, 8'h01, 0, '0);
    txn(0, 19'h7FFFF, 8'h00, 0, '0);
    txn(1, 19'h12345, 8'h80, 0, '0);
    txn(1, 19'h12346, 8'h7F, 0, '0);
    txn(0, 19'h12345, 8'h00, 0, '0);

    txn(0, 19'h12345, 8'h00, 1, 19'h00100);
    repeat (3) begin
      @(negedge clk);
      chk(mem_ce_n === 1'b1, "R8 busy request started no cycle", mem_ce_n, 1);
    end
    txn(0, 19'h00100, 8'h00, 0, '0);
    txn(1, 19'h00200, 8'h5A, 1, 19'h00200);
    repeat (2) @(negedge clk);
    txn(0, 19'h00200, 8'h00, 0, '0);

    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = {11'h0A5, 8'($urandom_range(0, 15))};
      if (i % 7 == 0) a = 19'h7FFFF;
      d = 8'($urandom);
      txn(1'($urandom), a, d, 0, '0);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule